// File: doc/BRIEF.md
# Nine-Tap Streaming Multiply-Accumulate

This block takes one signed sample and one signed filter coefficient on every clock and produces a convolution result for each run of nine consecutive pairs. Each pair is sign-extended to the accumulator width and multiplied. The products are summed in a running accumulator. No idle cycle separates one group of nine from the next. The pair that arrives on the boundary cycle is not discarded: it becomes the first term of the following group.

For each finished group the block raises a one-cycle write strobe. It presents the nine-term sum and a result address alongside it, so an external memory can capture all three in the same cycle. The address then advances by one. The caller supplies the coefficient sequence, and storing the results happens outside the block.

Top module: `conv_group_mac`

## Requirements
- R1: Each product equals the sample (signed, 5 bits) times the coefficient (signed, 3 bits), both sign-extended to the 8-bit accumulator width, taken as an 8-bit signed value.
- R2: An internal group position runs 0,1,...,8 and then returns to 0, advancing on every clock after reset with no idle state.
- R3: The write strobe is high for exactly one cycle in every nine. It is high in the cycle whose group position is 8, counting the first cycle after reset release as position 0, and it is low in every other cycle.
- R4: While the strobe is high, the result equals the wrapped sum of the nine products presented in the nine cycles just before the strobe cycle.
- R5: The product presented during a strobe cycle is the first term of the next group (the accumulator is reloaded with it rather than cleared), so back-to-back groups lose no pair.
- R6: The first group after reset holds only the eight pairs presented in cycles 0 to 7, because a zero term stands in for the missing ninth.
- R7: The result address reads 0 after reset and advances by one right after each strobe cycle, so during strobe number j (counting from 0) it reads j modulo 2^8.
- R8: The result output holds its value in every cycle in which the strobe is low.
- R9: An active-high asynchronous reset immediately forces the result, the strobe and the address to 0, without waiting for a clock edge.
- R10: Accumulation wraps in 8-bit two's complement, with no saturation (for example, nine products of 64 give 64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Asynchronous reset, active high |
| sample_i | input | 5 | Signed data sample for this cycle |
| coef_i | input | 3 | Signed filter coefficient for this cycle |
| result_o | output | 8 | Signed nine-product sum of the latest finished group |
| strobe_o | output | 1 | One-cycle write strobe marking a valid result |
| addr_o | output | 8 | Result address for the external memory |

## Verification
The assertions take for granted that a fresh pair arrives on every clock with no gaps, because the block has no input qualifier and counts every cycle as a sample. They also assume that sample and coefficient are never unknown, and that reset is applied before the first group. The stimulus meets these conditions. It drives defined values on every falling edge without pause, and it starts each phase with an asserted reset. Its phases are an exhaustive sweep of all 256 operand pairs, a constant extreme stream that forces wraparound, and a long random stream that carries the address past its wrap point. An asynchronous reset is applied mid-cycle during that stream.

// File: rtl/conv_mac_pkg.sv
package conv_mac_pkg;

   typedef enum logic [0:0] {
      PROD_WIDE   = 1'b0,
      PROD_NATIVE = 1'b1
   } prod_style_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mac_group_counter.sv
module mac_group_counter #(
   parameter int unsigned GROUP_LEN = 9,
   parameter int unsigned CNT_W     = conv_mac_pkg::idx_width(GROUP_LEN)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             last_o,
   output logic             prelast_o
);

   localparam logic [CNT_W-1:0] LAST_POS    = CNT_W'(GROUP_LEN - 1);
   localparam logic [CNT_W-1:0] PRELAST_POS = CNT_W'(GROUP_LEN - 2);

   initial begin
      assert (GROUP_LEN >= 2) else $error("GROUP_LEN must be at least 2");
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)
         cnt_o <= '0;
      else if (cnt_o == LAST_POS)
         cnt_o <= '0;
      else
         cnt_o <= cnt_o + 1'b1;
   end

   assign last_o    = (cnt_o == LAST_POS);
   assign prelast_o = (cnt_o == PRELAST_POS);

   // R2
   cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      last_o |=> (cnt_o == '0));

   // R2
   cnt_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !last_o |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/mac_product.sv
module mac_product
   import conv_mac_pkg::*;
#(
   parameter int unsigned SAMPLE_W   = 5,
   parameter int unsigned COEF_W     = 3,
   parameter int unsigned ACC_W      = 8,
   parameter prod_style_e PROD_STYLE = PROD_WIDE
) (
   input  logic signed [SAMPLE_W-1:0] a_i,
   input  logic signed [COEF_W-1:0]   b_i,
   output logic signed [ACC_W-1:0]    prod_o
);

   localparam int unsigned NAT_W = SAMPLE_W + COEF_W;

   initial begin
      assert (ACC_W >= SAMPLE_W && ACC_W >= COEF_W)
         else $error("ACC_W must cover both operand widths");
   end

   generate
      if (PROD_STYLE == PROD_WIDE) begin : g_wide
         logic signed [ACC_W-1:0] a_x, b_x;
         assign a_x    = ACC_W'(a_i);
         assign b_x    = ACC_W'(b_i);
         assign prod_o = a_x * b_x;
      end else begin : g_native
         logic signed [NAT_W-1:0] nat;
         assign nat    = a_i * b_i;
         assign prod_o = ACC_W'(nat);
      end
   endgenerate

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
   parameter int unsigned ACC_W = 8
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic signed [ACC_W-1:0] prod_i,
   input  logic                    restart_i,
   input  logic                    close_i,
   output logic signed [ACC_W-1:0] result_o,
   output logic                    strobe_o
);

   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] sum_next;

   assign sum_next = acc_q + prod_i;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         acc_q    <= '0;
         result_o <= '0;
         strobe_o <= 1'b0;
      end else begin
         acc_q    <= restart_i ? prod_i : sum_next;
         strobe_o <= close_i;
         if (close_i)
            result_o <= sum_next;
      end
   end

   // R8
   result_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !strobe_o |-> $stable(result_o));

   // R5
   reload_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      restart_i |=> (acc_q == $past(prod_i)));

endmodule

// File: rtl/mac_addr_gen.sv
module mac_addr_gen #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              advance_i,
   output logic [ADDR_W-1:0] addr_o
);

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)
         addr_o <= '0;
      else if (advance_i)
         addr_o <= addr_o + 1'b1;
   end

   // R7
   addr_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      advance_i |=> (addr_o == $past(addr_o) + 1'b1));

   // R7
   addr_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !advance_i |=> $stable(addr_o));

endmodule

// File: rtl/conv_group_mac.sv
module conv_group_mac
   import conv_mac_pkg::*;
#(
   parameter int unsigned SAMPLE_W   = 5,
   parameter int unsigned COEF_W     = 3,
   parameter int unsigned ACC_W      = 8,
   parameter int unsigned GROUP_LEN  = 9,
   parameter int unsigned ADDR_W     = 8,
   parameter prod_style_e PROD_STYLE = PROD_WIDE
) (
   input  logic                       clk_i,
   input  logic                       rst_i,
   input  logic signed [SAMPLE_W-1:0] sample_i,
   input  logic signed [COEF_W-1:0]   coef_i,
   output logic signed [ACC_W-1:0]    result_o,
   output logic                       strobe_o,
   output logic [ADDR_W-1:0]          addr_o
);

   localparam int unsigned     CNT_W    = idx_width(GROUP_LEN);
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(GROUP_LEN - 1);

   logic [CNT_W-1:0]        grp_pos;
   logic                    grp_last;
   logic                    grp_prelast;
   logic signed [ACC_W-1:0] prod;

   initial begin
      assert (ADDR_W >= 1) else $error("ADDR_W must be at least 1");
   end

   mac_group_counter #(
      .GROUP_LEN (GROUP_LEN),
      .CNT_W     (CNT_W)
   ) i_counter (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .cnt_o     (grp_pos),
      .last_o    (grp_last),
      .prelast_o (grp_prelast)
   );

   mac_product #(
      .SAMPLE_W   (SAMPLE_W),
      .COEF_W     (COEF_W),
      .ACC_W      (ACC_W),
      .PROD_STYLE (PROD_STYLE)
   ) i_product (
      .a_i    (sample_i),
      .b_i    (coef_i),
      .prod_o (prod)
   );

   mac_accum #(
      .ACC_W (ACC_W)
   ) i_accum (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .prod_i    (prod),
      .restart_i (grp_last),
      .close_i   (grp_prelast),
      .result_o  (result_o),
      .strobe_o  (strobe_o)
   );

   mac_addr_gen #(
      .ADDR_W (ADDR_W)
   ) i_addr (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .advance_i (grp_last),
      .addr_o    (addr_o)
   );

   // R3
   strobe_pos_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      strobe_o |-> (grp_pos == LAST_POS));

   // R3
   strobe_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      strobe_o |=> !strobe_o);

endmodule

// File: tb/test_conv_group_mac.sv
`timescale 1ns/1ps
module test_conv_group_mac;

   localparam int SW  = 5;
   localparam int CW  = 3;
   localparam int AW  = 8;
   localparam int GL  = 9;
   localparam int ADW = 8;

   logic                 clk = 1'b0;
   logic                 rst;
   logic signed [SW-1:0] smp;
   logic signed [CW-1:0] cf;
   logic signed [AW-1:0] result;
   logic                 strobe;
   logic [ADW-1:0]       addr;

   always #4 clk = ~clk;

   conv_group_mac #(
      .SAMPLE_W  (SW),
      .COEF_W    (CW),
      .ACC_W     (AW),
      .GROUP_LEN (GL),
      .ADDR_W    (ADW)
   ) i_conv_group_mac (
      .clk_i    (clk),
      .rst_i    (rst),
      .sample_i (smp),
      .coef_i   (cf),
      .result_o (result),
      .strobe_o (strobe),
      .addr_o   (addr)
   );

   int errors = 0;
   int checks = 0;
   int prods [0:4095];
   int n;
   logic signed [AW-1:0] last_res;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // called at a falling edge: check outputs of cycle n, then drive pair n
   task automatic step(input logic signed [SW-1:0] a, input logic signed [CW-1:0] b);
      bit exp_strobe;
      int s;
      logic signed [AW-1:0] exp_res;
      exp_strobe = ((n % GL) == GL - 1);
      check(strobe == exp_strobe, "R3", "strobe", int'(strobe), int'(exp_strobe));
      check(addr == ADW'(n / GL), "R7", "address", int'(addr), (n / GL) % (1 << ADW));
      if (exp_strobe) begin
         s = 0;
         for (int k = n - GL; k < n; k++)
            if (k >= 0) s += prods[k];
         exp_res = AW'(s);
         // R1 R4 R5 R6 R10: nine-product wrapped sum, reload keeps boundary pair
         check(result == exp_res, (n == GL - 1) ? "R6" : "R4", "group sum",
               int'(result), int'(exp_res));
         last_res = exp_res;
      end else begin
         check(result == last_res, "R8", "held result", int'(result), int'(last_res));
      end
      prods[n] = int'(a) * int'(b);
      n++;
      smp = a;
      cf  = b;
      @(negedge clk);
   endtask

   task automatic fresh_reset();
      rst = 1'b1;
      smp = '0;
      cf  = '0;
      repeat (3) @(negedge clk);
      // R9: reset state
      check(result == '0, "R9", "reset result", int'(result), 0);
      check(strobe == 1'b0, "R9", "reset strobe", int'(strobe), 0);
      check(addr == '0, "R9", "reset address", int'(addr), 0);
      rst = 1'b0;
      n = 0;
      last_res = '0;
   endtask

   initial begin
      // phase 1: every operand pair, then zero padding to close groups
      fresh_reset();
      for (int a = -(1 << (SW - 1)); a < (1 << (SW - 1)); a++)
         for (int b = -(1 << (CW - 1)); b < (1 << (CW - 1)); b++)
            step(SW'(a), CW'(b));
      for (int i = 0; i < 2 * GL; i++)
         step('0, '0);

      // phase 2: extreme constant streams force wraparound (R10)
      fresh_reset();
      for (int i = 0; i < 4 * GL; i++)
         step(SW'(-16), CW'(-4));
      for (int i = 0; i < 4 * GL; i++)
         step(SW'(-16), CW'(3));
      for (int i = 0; i < 2 * GL; i++)
         step(SW'(15), CW'(-4));

      // phase 3: long random stream, address passes its wrap point (R7)
      fresh_reset();
      for (int i = 0; i < 2400; i++)
         step(SW'($urandom), CW'($urandom));

      // R9: asynchronous reset mid-cycle, seen before any clock edge
      @(posedge clk);
      #2;
      rst = 1'b1;
      #1;
      check(result == '0, "R9", "async result", int'(result), 0);
      check(strobe == 1'b0, "R9", "async strobe", int'(strobe), 0);
      check(addr == '0, "R9", "async address", int'(addr), 0);

      // short restart after the async reset
      fresh_reset();
      for (int i = 0; i < 3 * GL; i++)
         step(SW'($urandom), CW'($urandom));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule